// File: doc/BRIEF.md
# Bus Cycle Wait-State Generator

This block stretches a processor bus machine cycle by exactly one clock so that a memory slower than the processor's nominal access time can still be read and written. It watches the address latch enable strobe. When it sees that strobe on a rising clock edge, it pulls the READY line low for one clock period on the next edge, and then releases it on the edge after that. The processor samples READY, sees it low, and adds a single wait state to the cycle that is in progress.

Two chained registers produce the wait. The first one captures the latch-enable strobe. The second one drives READY, and its low state clears the first one. As a result the wait ends by itself, and exactly one wait is produced for each accepted strobe. The parameter `SELECTIVE` chooses between two builds. With `SELECTIVE` = 0, every machine cycle gets a wait. With `SELECTIVE` = 1, only cycles where the active-low cycle-select input is 0 when the strobe is sampled get a wait.

Top module: `bus_wait_gen`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge after it rises, `ready` is 1 and no wait is pending.
- R2: A strobe is accepted when `ale` is 1 at a rising edge (edge k), READY is high, no wait is already pending, and the cycle qualifies. After an accepted strobe, `ready` stays 1 after edge k and reads 0 after edge k+1.
- R3: Each accepted strobe holds `ready` at 0 for exactly one clock period. It returns to 1 after edge k+2 with no further input needed.
- R4: An `ale` sample is ignored, with no effect on `ready`, in two cases: when it falls on an edge where a wait is already pending, or when it falls on an edge where `ready` is 0.
- R5: With `SELECTIVE` = 1, a strobe sampled while `cyc_sel_n` = 1 produces no wait. `ready` stays 1.
- R6: With `SELECTIVE` = 0, every strobe that is accepted under R2/R4 produces a wait, whatever the value of `cyc_sel_n`.
- R7: Machine cycles may follow back to back. A strobe sampled on the first edge where `ready` is 1 again produces a new single wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock output; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous system reset |
| ale | input | 1 | Address latch enable strobe, sampled on the rising edge |
| cyc_sel_n | input | 1 | Active-low cycle select (used only when `SELECTIVE` = 1) |
| ready | output | 1 | Ready line to the processor; 0 requests a wait state |

## Verification
Two builds are run side by side on the same inputs: the selective build and the every-cycle build. Each stimulus pattern separates them in a different way.
- A lone strobe with the cycle selected shows the one-clock latency and the one-clock width.
- A lone strobe with the cycle not selected makes the two builds disagree. That shows the selection gate is active only in the selective build.
- A strobe held high for several clocks checks that repeats landing on the pending edge or the low edge are ignored. Only later samples start a new wait.
- Strobes placed on the earliest legal edge check the back-to-back restart.
- Randomly mixed strobe and select patterns cover the remaining orderings.

// File: rtl/bus_wait_gen.sv
module bus_wait_gen #(
  parameter bit SELECTIVE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ale,
  input  logic cyc_sel_n,
  output logic ready
);

  logic armed;
  logic ready_q;
  logic cycle_ok;

  generate
    if (SELECTIVE) begin : g_sel
      assign cycle_ok = ~cyc_sel_n;
    end else begin : g_all
      assign cycle_ok = 1'b1;
      logic unused_sel;
      assign unused_sel = cyc_sel_n;
    end
  endgenerate

  // capture flop: cleared while the ready flop is low or once it has fired
  always_ff @(posedge clk) begin
    if (!rst_n)
      armed <= 1'b0;
    else
      armed <= ready_q & ~armed & ale & cycle_ok;
  end

  // ready flop: goes low the edge after capture, returns high one edge later
  always_ff @(posedge clk) begin
    if (!rst_n)
      ready_q <= 1'b1;
    else
      ready_q <= ~armed;
  end

  assign ready = ready_q;

endmodule

module bus_wait_gen_chk #(
  parameter bit SELECTIVE = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic cyc_sel_n,
  input logic ready,
  input logic armed
);

  a_r1_ready_in_reset: assert property (@(posedge clk)
    !rst_n |=> ready);

  a_r2_wait_follows_capture: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> !ready);

  a_r2_low_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(armed));

  a_r3_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);

  a_r4_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ##1 ready);

  a_r5_unselected_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (SELECTIVE && cyc_sel_n && ready && !armed) |=> ##1 ready);

  a_r6_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!SELECTIVE && ale && ready && !armed) |=> ##1 !ready);

endmodule

bind bus_wait_gen bus_wait_gen_chk #(.SELECTIVE(SELECTIVE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .cyc_sel_n(cyc_sel_n),
  .ready(ready), .armed(armed)
);

// File: tb/bus_wait_gen_test.sv
`timescale 1ns/1ps
module bus_wait_gen_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0;
  logic cyc_sel_n = 1'b1;
  logic rdy_s, rdy_p;

  always #2 clk = ~clk;

  bus_wait_gen #(.SELECTIVE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cyc_sel_n(cyc_sel_n), .ready(rdy_s));

  bus_wait_gen #(.SELECTIVE(1'b0)) uut_all (
    .clk(clk), .rst_n(rst_n), .ale(ale), .cyc_sel_n(cyc_sel_n), .ready(rdy_p));

  typedef enum logic [1:0] {M_IDLE, M_ARMED, M_LOW} mstate_t;

  mstate_t ms = M_IDLE, mp = M_IDLE;
  string tag_s = "R1", tag_p = "R1";
  int total = 0, bad = 0;
  int run_s = 0, run_p = 0;
  bit done = 0;

  function automatic logic exp_ready(mstate_t st);
    return st != M_LOW;
  endfunction

  function automatic mstate_t next_state(mstate_t st, logic a, logic ok);
    case (st)
      M_IDLE:  return (a && ok) ? M_ARMED : M_IDLE;
      M_ARMED: return M_LOW;
      default: return M_IDLE;
    endcase
  endfunction

  function automatic string pick_tag(mstate_t st, logic a, logic ok, logic sel_build, logic sel_n);
    if (st == M_IDLE && a && ok) return sel_build ? "R2" : "R6";
    if (st == M_IDLE && a && sel_build && sel_n) return "R5";
    if (st != M_IDLE && a) return "R4";
    return "R3";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ms <= M_IDLE; mp <= M_IDLE; tag_s <= "R1"; tag_p <= "R1";
    end else begin
      ms <= next_state(ms, ale, !cyc_sel_n);
      mp <= next_state(mp, ale, 1'b1);
      tag_s <= (ms == M_LOW || ms == M_IDLE) && ale && !cyc_sel_n && ms == M_IDLE && !exp_ready(ms) ? "R7"
             : pick_tag(ms, ale, !cyc_sel_n, 1'b1, cyc_sel_n);
      tag_p <= pick_tag(mp, ale, 1'b1, 1'b0, cyc_sel_n);
    end
  end

  task automatic check(string tag, logic act, logic exp, string who);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: ready=%0b expected=%0b at %0t", tag, who, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(tag_s, rdy_s, exp_ready(ms), "selective");
      check(tag_p, rdy_p, exp_ready(mp), "every-cycle");
      if (rst_n) begin
        if (!rdy_s) run_s++;
        else if (run_s != 0) begin check("R3", run_s == 1, 1'b1, "selective width"); run_s = 0; end
        if (!rdy_p) run_p++;
        else if (run_p != 0) begin check("R3", run_p == 1, 1'b1, "every-cycle width"); run_p = 0; end
      end
    end
  end

  task automatic step(logic a, logic sn);
    @(negedge clk);
    #1;
    ale = a;
    cyc_sel_n = sn;
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    ale = 1'b1; cyc_sel_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 ale = 1'b0; rst_n = 1'b1;
    step(0, 1);
    // R2 lone selected strobe
    step(1, 0); step(0, 1); step(0, 1); step(0, 1);
    // R5 / R6 unselected strobe
    step(1, 1); step(0, 1); step(0, 1); step(0, 1);
    // R4 strobe held for five clocks
    repeat (5) step(1, 0);
    step(0, 1); step(0, 1);
    // R7 earliest back-to-back restart
    step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0); step(0, 0);
    step(1, 0); step(0, 1); step(0, 1); step(0, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 3) == 0, $urandom % 2);
      if ((i % 997) == 500) begin
        @(negedge clk); #1 rst_n = 1'b0;
        @(negedge clk); #1 rst_n = 1'b1;
      end
    end
    step(0, 1); step(0, 1); step(0, 1);
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not end, actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule